// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block conditions a small set of external interrupt pins, either four or six depending on a parameter, and turns each one into a request line. Every pin first passes through a two-flop synchroniser. Each pin then follows its own trigger rule: it can respond to a level, high or low, or to an edge, which may be rising, falling or either. Edge events are held in a sticky pending bit until software acknowledges them. A per-pin enable gates the request without affecting the capture of events.

Software controls the block through two 32-bit configuration words. One byte in each word belongs to one pin. A write updates every pin field in the selected word at the same time, and a read returns the configuration together with the live pending state.

The requests are routed to one of two places, chosen by a routing input. They either drive dedicated request lines, or they drive a window of sources in a wider internal interrupt vector. In the second case, every change of a pin's enable bit also emits a one-cycle enable or disable pulse for the matching internal source. This keeps the internal mask in step with the pin mask.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset every request output is 0. Each pin's byte reads 0x02: enable 0, level mode 1, polarity 0, any-edge 0. This means active-low level, disabled.
- R2: Each pin input is sampled through two flops. A change driven on the pin is not visible at the request after one rising clock edge, and becomes visible after the second.
- R3: With level mode 1 and polarity 1, the request of an enabled pin equals the synchronised input, and no pending event is ever recorded.
- R4: With level mode 1 and polarity 0, the request of an enabled pin equals the inverse of the synchronised input.
- R5: With level mode 0, polarity 1 and any-edge 0, a rising edge sets the pending bit. The request rises on the third clock edge after the pin change and stays high after the pin returns, until acknowledged.
- R6: With level mode 0, polarity 0 and any-edge 0, only a falling edge sets the pending bit; a rising edge does nothing.
- R7: With level mode 0 and any-edge 1, both edges set the pending bit. With level mode 1, the any-edge bit has no effect and nothing latches.
- R8: An edge event is recorded even while the pin is disabled. A disabled pin raises no request. Setting enable while an event is pending raises the request right after that write.
- R9: Writing 1 to a pin's acknowledge bit clears its pending bit, and the acknowledge bit always reads 0. Writing 0 to it leaves pending unchanged. If a new event arrives on the same clock edge as an acknowledge, the event wins.
- R10: Register select 0 holds pins 0 to 3 and select 1 holds pins 4 and up. Pin p owns bits 8*(p%4)+7 down to 8*(p%4). Within that byte: bit0 is enable, bit1 is level mode, bit2 is polarity high, bit3 is any-edge, bit4 is acknowledge (write-one) and bit5 is pending (read-only). All other bits, and the bytes of absent pins, read 0 and ignore writes.
- R11: With the routing input at 0, pin k's request appears on dedicated line k and the internal vector is 0. With the routing input at 1, it appears on internal bit CASCADE_BASE+k and the dedicated lines are 0.
- R12: With the routing input at 1, a write that changes pin k's enable from 1 to 0 gives a one-cycle pulse on disable bit CASCADE_BASE+k. A change from 0 to 1 gives a one-cycle pulse on enable bit CASCADE_BASE+k. A write that leaves the enable unchanged gives no pulse, and with the routing input at 0 no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_PINS | Raw external interrupt pins |
| regWrEn | input | 1 | Write strobe for the selected configuration word |
| regSel | input | 1 | Configuration word select: 0 for pins 0-3, 1 for pins 4 and up |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected word |
| cascadeEn | input | 1 | Routes requests into the internal vector instead of the dedicated lines |
| dedicatedReq | output | NUM_PINS | Per-pin request lines |
| cascadeReq | output | INT_SRCS | Internal source vector carrying the requests at CASCADE_BASE+k |
| intSrcEnable | output | INT_SRCS | One-cycle enable pulses for internal sources |
| intSrcDisable | output | INT_SRCS | One-cycle disable pulses for internal sources |

## Verification
Directed sequences step one pin through each trigger mode in turn. A level that must track, a rising pulse that must latch, and a rising pulse on a falling-edge pin that must be ignored together separate the level, polarity and any-edge decodes. Pulses on a disabled pin, acknowledges written with 0, and an acknowledge that lands on the same edge as a fresh event separate the sticky latch from the enable gate and fix the priority between set and clear. A long random run then toggles pins, routing and full-word writes, with random acknowledge bits. This exposes cross-talk between pins that share a word and between the two words, which the directed steps would miss.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int PINS_PER_REG = 4;
  localparam int FIELD_W      = 8;
  localparam int REG_W        = PINS_PER_REG * FIELD_W;
  localparam int MAX_PINS     = 8;
  localparam int SYNC_STAGES  = 2;

  // bit positions inside one pin byte
  localparam int F_EN   = 0;
  localparam int F_LVL  = 1;
  localparam int F_POL  = 2;
  localparam int F_ANY  = 3;
  localparam int F_ACK  = 4;
  localparam int F_PEND = 5;

  typedef struct packed {
    logic anyEdge;
    logic polHigh;
    logic levelMode;
    logic enable;
  } pinCfg_t;

  // untouched pins behave as active-low level, disabled
  localparam pinCfg_t CFG_RESET = '{anyEdge: 1'b0, polHigh: 1'b0, levelMode: 1'b1, enable: 1'b0};

  typedef struct packed {
    logic [MAX_PINS-1:0] ackHit;
  } dpStrobe_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PINS-1:0]          pinIn,
  input  pinCfg_t [NUM_PINS-1:0]       cfgVec,
  input  dpStrobe_t                    strobe,
  output logic [NUM_PINS-1:0]          pendVec,
  output logic [NUM_PINS-1:0]          reqVec
);
  logic [NUM_PINS-1:0] syncIn;
  logic [NUM_PINS-1:0] prevIn;
  logic [NUM_PINS-1:0] eventVec;
  logic [NUM_PINS-1:0] levelVec;
  logic [NUM_PINS-1:0] ackVec;
  logic                unusedStrobe;

  ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (syncIn)
  );

  assign ackVec       = strobe.ackHit[NUM_PINS-1:0];
  assign unusedStrobe = ^strobe.ackHit;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic riseHit;
    logic fallHit;
    logic edgeHit;
    assign riseHit = syncIn[g] & ~prevIn[g];
    assign fallHit = ~syncIn[g] & prevIn[g];
    assign edgeHit = cfgVec[g].anyEdge ? (riseHit | fallHit)
                   : (cfgVec[g].polHigh ? riseHit : fallHit);
    assign eventVec[g] = ~cfgVec[g].levelMode & edgeHit;
    assign levelVec[g] = cfgVec[g].levelMode &
                         (cfgVec[g].polHigh ? syncIn[g] : ~syncIn[g]);
    assign reqVec[g]   = cfgVec[g].enable & (pendVec[g] | levelVec[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn  <= '0;
      pendVec <= '0;
    end else begin
      prevIn  <= syncIn;
      pendVec <= eventVec | (pendVec & ~ackVec);
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS     = 6,
  parameter int INT_SRCS     = 64,
  parameter int CASCADE_BASE = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic                    regSel,
  input  logic [REG_W-1:0]        regWrData,
  input  logic                    cascadeEn,
  input  logic [NUM_PINS-1:0]     pendVec,
  output pinCfg_t [NUM_PINS-1:0]  cfgVec,
  output dpStrobe_t               strobe,
  output logic [REG_W-1:0]        regRdData,
  output logic [INT_SRCS-1:0]     intSrcEnable,
  output logic [INT_SRCS-1:0]     intSrcDisable
);
  logic [NUM_PINS-1:0]     pinHit;
  logic [FIELD_W-1:0]      fieldW [NUM_PINS];
  pinCfg_t [NUM_PINS-1:0]  cfgNext;
  logic [INT_SRCS-1:0]     enNext;
  logic [INT_SRCS-1:0]     disNext;
  logic                    unusedWrBits;

  assign unusedWrBits = ^regWrData;

  always_comb begin
    strobe  = '0;
    enNext  = '0;
    disNext = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      pinHit[k] = regWrEn && (int'(regSel) == k / PINS_PER_REG);
      fieldW[k] = regWrData[FIELD_W*(k%PINS_PER_REG) +: FIELD_W];
      cfgNext[k] = cfgVec[k];
      if (pinHit[k]) begin
        cfgNext[k].enable    = fieldW[k][F_EN];
        cfgNext[k].levelMode = fieldW[k][F_LVL];
        cfgNext[k].polHigh   = fieldW[k][F_POL];
        cfgNext[k].anyEdge   = fieldW[k][F_ANY];
      end
      strobe.ackHit[k] = pinHit[k] & fieldW[k][F_ACK];
      if (pinHit[k] && cascadeEn) begin
        if (fieldW[k][F_EN] && !cfgVec[k].enable)  enNext[CASCADE_BASE+k]  = 1'b1;
        if (!fieldW[k][F_EN] && cfgVec[k].enable)  disNext[CASCADE_BASE+k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgVec        <= {NUM_PINS{CFG_RESET}};
      intSrcEnable  <= '0;
      intSrcDisable <= '0;
    end else begin
      cfgVec        <= cfgNext;
      intSrcEnable  <= enNext;
      intSrcDisable <= disNext;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (int'(regSel) == k / PINS_PER_REG) begin
        regRdData[FIELD_W*(k%PINS_PER_REG) + F_EN]   = cfgVec[k].enable;
        regRdData[FIELD_W*(k%PINS_PER_REG) + F_LVL]  = cfgVec[k].levelMode;
        regRdData[FIELD_W*(k%PINS_PER_REG) + F_POL]  = cfgVec[k].polHigh;
        regRdData[FIELD_W*(k%PINS_PER_REG) + F_ANY]  = cfgVec[k].anyEdge;
        regRdData[FIELD_W*(k%PINS_PER_REG) + F_PEND] = pendVec[k];
      end
    end
  end
endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS     = 6,
  parameter int INT_SRCS     = 64,
  parameter int CASCADE_BASE = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                regWrEn,
  input  logic                regSel,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic                cascadeEn,
  output logic [NUM_PINS-1:0] dedicatedReq,
  output logic [INT_SRCS-1:0] cascadeReq,
  output logic [INT_SRCS-1:0] intSrcEnable,
  output logic [INT_SRCS-1:0] intSrcDisable
);
  pinCfg_t [NUM_PINS-1:0] cfgVec;
  dpStrobe_t              strobe;
  logic [NUM_PINS-1:0]    pendVec;
  logic [NUM_PINS-1:0]    reqVec;
  logic [NUM_PINS-1:0]    enVec;
  logic [NUM_PINS-1:0]    lvlVec;

  ext_irq_ctrl #(
    .NUM_PINS(NUM_PINS), .INT_SRCS(INT_SRCS), .CASCADE_BASE(CASCADE_BASE)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regSel        (regSel),
    .regWrData     (regWrData),
    .cascadeEn     (cascadeEn),
    .pendVec       (pendVec),
    .cfgVec        (cfgVec),
    .strobe        (strobe),
    .regRdData     (regRdData),
    .intSrcEnable  (intSrcEnable),
    .intSrcDisable (intSrcDisable)
  );

  ext_irq_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .cfgVec  (cfgVec),
    .strobe  (strobe),
    .pendVec (pendVec),
    .reqVec  (reqVec)
  );

  always_comb begin
    for (int k = 0; k < NUM_PINS; k++) begin
      enVec[k]  = cfgVec[k].enable;
      lvlVec[k] = cfgVec[k].levelMode;
    end
    dedicatedReq = cascadeEn ? '0 : reqVec;
    cascadeReq   = '0;
    if (cascadeEn) cascadeReq[CASCADE_BASE +: NUM_PINS] = reqVec;
  end
endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker #(
  parameter int NUM_PINS = 6,
  parameter int INT_SRCS = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                cascadeEn,
  input logic [NUM_PINS-1:0] dedicatedReq,
  input logic [INT_SRCS-1:0] cascadeReq,
  input logic [INT_SRCS-1:0] intSrcEnable,
  input logic [INT_SRCS-1:0] intSrcDisable,
  input logic [NUM_PINS-1:0] reqVec,
  input logic [NUM_PINS-1:0] enVec,
  input logic [NUM_PINS-1:0] lvlVec,
  input logic [NUM_PINS-1:0] pendVec
);
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec & ~enVec) == '0); // R8

  AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !((|dedicatedReq) && (|cascadeReq))); // R11

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~$past(pendVec)) & $past(lvlVec)) == '0); // R3

  AST_PULSE_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    ((|intSrcEnable) || (|intSrcDisable)) |-> $past(cascadeEn)); // R12

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (intSrcEnable & intSrcDisable) == '0); // R12

  AST_DISABLE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (|intSrcDisable) |=> (intSrcDisable & $past(intSrcDisable)) == '0); // R12
endmodule

bind ext_irq_trigger ext_irq_checker #(.NUM_PINS(NUM_PINS), .INT_SRCS(INT_SRCS)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .cascadeEn     (cascadeEn),
  .dedicatedReq  (dedicatedReq),
  .cascadeReq    (cascadeReq),
  .intSrcEnable  (intSrcEnable),
  .intSrcDisable (intSrcDisable),
  .reqVec        (reqVec),
  .enVec         (enVec),
  .lvlVec        (lvlVec),
  .pendVec       (pendVec)
);

// File: tb/ext_irq_trigger_test.sv
`timescale 1ns/1ps
module ext_irq_trigger_test;
  localparam int P = 6;
  localparam int S = 64;
  localparam int B = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [P-1:0]  pinIn = '0;
  logic          regWrEn = 1'b0;
  logic          regSel = 1'b0;
  logic [31:0]   regWrData = '0;
  logic          cascadeEn = 1'b0;
  logic [31:0]   regRdData;
  logic [P-1:0]  dedicatedReq;
  logic [S-1:0]  cascadeReq, intSrcEnable, intSrcDisable;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  ext_irq_trigger #(.NUM_PINS(P), .INT_SRCS(S), .CASCADE_BASE(B)) uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .cascadeEn(cascadeEn),
    .dedicatedReq(dedicatedReq), .cascadeReq(cascadeReq),
    .intSrcEnable(intSrcEnable), .intSrcDisable(intSrcDisable)
  );

  always #5 clk = ~clk;

  // behavioural expectation built from the requirements
  logic [P-1:0] mS0, mS1, mPrev, mPend, mEn, mLvl, mPol, mAny;
  logic [S-1:0] mEnP, mDisP;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS0 <= '0; mS1 <= '0; mPrev <= '0; mPend <= '0;
      mEn <= '0; mLvl <= '1; mPol <= '0; mAny <= '0;
      mEnP <= '0; mDisP <= '0;
    end else begin
      mEnP <= '0;
      mDisP <= '0;
      for (int k = 0; k < P; k++) begin
        logic ev, hit;
        logic [7:0] f;
        ev = !mLvl[k] && (mAny[k] ? (mS1[k] ^ mPrev[k])
                        : (mPol[k] ? (mS1[k] & ~mPrev[k]) : (~mS1[k] & mPrev[k])));
        hit = regWrEn && (int'(regSel) == k / 4);
        f = regWrData[8*(k%4) +: 8];
        mPend[k] <= ev | (mPend[k] & ~(hit & f[4]));
        if (hit) begin
          mEn[k] <= f[0]; mLvl[k] <= f[1]; mPol[k] <= f[2]; mAny[k] <= f[3];
          if (cascadeEn && f[0] && !mEn[k]) mEnP[B+k] <= 1'b1;
          if (cascadeEn && !f[0] && mEn[k]) mDisP[B+k] <= 1'b1;
        end
      end
      mS0 <= pinIn; mS1 <= mS0; mPrev <= mS1;
    end
  end

  function automatic logic [P-1:0] modelReq();
    logic [P-1:0] r;
    for (int k = 0; k < P; k++)
      r[k] = mEn[k] & (mPend[k] | (mLvl[k] & (mPol[k] ? mS1[k] : ~mS1[k])));
    return r;
  endfunction

  function automatic logic [31:0] modelRead(input logic sel);
    logic [31:0] r = '0;
    for (int k = 0; k < P; k++)
      if (k / 4 == int'(sel))
        r[8*(k%4) +: 8] = {2'b00, mPend[k], 1'b0, mAny[k], mPol[k], mLvl[k], mEn[k]};
    return r;
  endfunction

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic sel, input logic [31:0] d);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic sel, output logic [31:0] d);
    regSel = sel;
    #1 d = regRdData;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, r0, r1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    chk(64'(dedicatedReq), 64'h0, "R1 dedicated after reset");
    chk(cascadeReq, 64'h0, "R1 cascade after reset");
    rdReg(0, rd); chk(64'(rd), 64'h02020202, "R1 word0 reset value");
    rdReg(1, rd); chk(64'(rd), 64'h00000202, "R10 word1 absent bytes");

    // R2 / R3 level high on pin0
    r0 = 32'h02020207; wrReg(0, r0);
    pinIn[0] = 1'b1; tick(1);
    chk(64'(dedicatedReq), 64'h0, "R2 one edge not enough");
    tick(1);
    chk(64'(dedicatedReq), 64'h01, "R3 level high tracks");
    pinIn[0] = 1'b0; tick(2);
    chk(64'(dedicatedReq), 64'h0, "R3 level high released");

    // R4 level low on pin1
    r0 = 32'h02020307; wrReg(0, r0);
    chk(64'(dedicatedReq), 64'h02, "R4 level low active");
    pinIn[1] = 1'b1; tick(2);
    chk(64'(dedicatedReq), 64'h0, "R4 level low inactive");

    // R5 rising edge on pin2
    r0 = 32'h02050307; wrReg(0, r0);
    pinIn[2] = 1'b1; tick(2);
    chk(64'(dedicatedReq), 64'h0, "R5 not yet latched");
    tick(1);
    chk(64'(dedicatedReq), 64'h04, "R5 rising latched");
    pinIn[2] = 1'b0; tick(4);
    chk(64'(dedicatedReq), 64'h04, "R5 held after pin low");
    rdReg(0, rd); chk(64'(rd), 64'h02250307, "R10 pending readback");
    wrReg(0, r0 | 32'h00100000);
    chk(64'(dedicatedReq), 64'h0, "R9 ack clears");
    rdReg(0, rd); chk(64'(rd), 64'h02050307, "R9 ack reads zero");

    // R6 falling edge on pin3
    r0 = 32'h01050307; wrReg(0, r0);
    pinIn[3] = 1'b1; tick(4);
    chk(64'(dedicatedReq), 64'h0, "R6 rising ignored");
    pinIn[3] = 1'b0; tick(2);
    chk(64'(dedicatedReq), 64'h0, "R6 falling not yet");
    tick(1);
    chk(64'(dedicatedReq), 64'h08, "R6 falling latched");
    wrReg(0, r0 | 32'h10000000);
    chk(64'(dedicatedReq), 64'h0, "R6 ack");

    // R7 both edges on pin4, any-edge ignored in level mode on pin5
    r1 = 32'h00000209; wrReg(1, r1);
    pinIn[4] = 1'b1; tick(3);
    chk(64'(dedicatedReq), 64'h10, "R7 rising on any-edge");
    wrReg(1, r1 | 32'h10);
    chk(64'(dedicatedReq), 64'h0, "R7 ack after rise");
    pinIn[4] = 1'b0; tick(3);
    chk(64'(dedicatedReq), 64'h10, "R7 falling on any-edge");
    wrReg(1, r1 | 32'h10);
    r1 = 32'h00000F09; wrReg(1, r1);
    chk(64'(dedicatedReq), 64'h0, "R7 level high idle");
    pinIn[5] = 1'b1; tick(2);
    chk(64'(dedicatedReq), 64'h20, "R7 level mode tracks");
    pinIn[5] = 1'b0; tick(2);
    chk(64'(dedicatedReq), 64'h0, "R7 level mode no latch");

    // R8 event while disabled
    r0 = 32'h01040307; wrReg(0, r0);
    pinIn[2] = 1'b1; tick(1); pinIn[2] = 1'b0; tick(4);
    chk(64'(dedicatedReq), 64'h0, "R8 disabled no request");
    rdReg(0, rd); chk(64'(rd), 64'h01240307, "R8 pending while disabled");
    r0 = 32'h01050307; wrReg(0, r0);
    chk(64'(dedicatedReq), 64'h04, "R8 enable shows pending");
    wrReg(0, r0 | 32'h00100000);

    // R9 ack written as 0, and ack coinciding with an event
    pinIn[2] = 1'b1; tick(3);
    chk(64'(dedicatedReq), 64'h04, "R9 set before zero-ack");
    wrReg(0, r0);
    chk(64'(dedicatedReq), 64'h04, "R9 zero ack keeps pending");
    pinIn[2] = 1'b0; tick(2);
    wrReg(0, r0 | 32'h00100000);
    pinIn[2] = 1'b1; tick(2);
    wrReg(0, r0 | 32'h00100000);
    chk(64'(dedicatedReq), 64'h04, "R9 event wins over ack");
    wrReg(0, r0 | 32'h00100000);
    chk(64'(dedicatedReq), 64'h0, "R9 final ack");

    // R10 absent bytes ignore writes
    wrReg(1, 32'hFFFF0F09);
    rdReg(1, rd); chk(64'(rd), 64'h00000F09, "R10 absent bytes ignore write");

    // R11 routing
    pinIn[1] = 1'b0; tick(2);
    chk(64'(dedicatedReq), 64'h02, "R11 dedicated route");
    cascadeEn = 1'b1; tick(1);
    chk(64'(dedicatedReq), 64'h0, "R11 dedicated silent");
    chk(cascadeReq, 64'h1 << (B+1), "R11 cascade route");

    // R12 mask pulses
    wrReg(0, 32'h01050306);
    chk(intSrcDisable, 64'h1 << B, "R12 disable pulse");
    chk(intSrcEnable, 64'h0, "R12 no enable pulse");
    tick(1);
    chk(intSrcDisable, 64'h0, "R12 pulse one cycle");
    wrReg(0, 32'h01050306);
    chk(intSrcDisable, 64'h0, "R12 unchanged no pulse");
    wrReg(0, 32'h01050307);
    chk(intSrcEnable, 64'h1 << B, "R12 enable pulse");
    cascadeEn = 1'b0;
    wrReg(0, 32'h01050306);
    chk(intSrcDisable | intSrcEnable, 64'h0, "R12 no pulse when not routed");

    // random phase against the behavioural expectation
    for (int i = 0; i < 3000; i++) begin
      logic [P-1:0] mr;
      mr = modelReq();
      chk(64'(dedicatedReq), cascadeEn ? 64'h0 : 64'(mr), "R5 random dedicated");
      chk(cascadeReq, cascadeEn ? (64'(mr) << B) : 64'h0, "R11 random cascade");
      chk(64'(regRdData), 64'(modelRead(regSel)), "R10 random read");
      chk(intSrcEnable, mEnP, "R12 random enable pulse");
      chk(intSrcDisable, mDisP, "R12 random disable pulse");
      for (int k = 0; k < P; k++) if ($urandom % 4 == 0) pinIn[k] = ~pinIn[k];
      regWrEn = ($urandom % 6 == 0);
      regSel = 1'($urandom % 2);
      regWrData = $urandom;
      if ($urandom % 50 == 0) cascadeEn = ~cascadeEn;
      @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule